// File: doc/BRIEF.md
# Receive Sampling Tap Tuner

This block is a hardware sequencer that picks the receive sampling tap for a high-speed card interface. Once started, it steps a tap value upward from zero through a capped range. Each step writes the tap into a 6-bit field and raises an update flag. The block waits for the hardware to clear that flag, asks an external tester for one tuning-block test, and takes the pass/fail verdict. While it steps, it keeps the length of the current run of consecutive good taps and of the longest run found so far, with the tap where that longest run ended.

When the sweep is over, the block writes back the tap at the middle of the longest run and pulses `done` once the flag for that write has cleared. The chosen tap stays on `tap_field` afterwards. If no tap passed, or if the final write never completes, it pulses `err` instead. Tuning runs only when the requested speed mode is the 200 MHz single-data-rate card mode, code 3'd4. A start in any other mode is refused on the spot.

The test request follows valid/ready rules. `test_valid` stays high and `tap_field` stays steady until `test_ready` is seen high at a clock edge. The tester may present `res_valid` at any time, and it must hold `res_valid` and `res_pass` until a clock edge where `res_ready` is high. `res_ready` is high only while the block waits for a verdict.

Top module: `tap_window_tuner`

## Requirements
- R1: After reset, `done`, `err`, `upd_flag`, `test_valid` and `res_ready` are low and `tap_field` is 0.
- R2: Each tap is applied by loading `tap_field` and raising `upd_flag`. The flag stays high, with `tap_field` unchanged, until `upd_clear` is sampled high, and no test is requested while it is high.
- R3: A sweep applies taps 0 to TAP_COUNT-1 (default 39) in ascending order, and requests exactly one test for each tap whose update completed.
- R4: A failed test, or an update whose flag is still set after UPD_TIMEOUT cycles (counted as a failed tap), resets the current run length to zero. The sweep then continues with the next tap.
- R5: The best run is replaced only by a strictly longer run, so of two equally long runs the earlier one is kept.
- R6: The final tap is the best run's last tap minus half its length, rounded down. It is applied through the same flag handshake. `done` is then high for exactly one cycle and `tap_field` keeps the chosen tap.
- R7: If no tap passed, `err` pulses for one cycle after the sweep and no final tap is applied.
- R8: A start with `mode` other than 3'd4 makes `err` high for one cycle, in the cycle after the start is sampled, without raising `upd_flag` or `test_valid`.
- R9: `test_valid` is held until accepted by `test_ready`, and a verdict is taken only on a cycle with both `res_valid` and `res_ready` high.
- R10: If the final tap's update times out, the run ends with an `err` pulse and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin tuning (sampled when idle) |
| mode | input | 3 | Speed mode code; 3'd4 enables tuning |
| done | output | 1 | One-cycle pulse: final tap applied |
| err | output | 1 | One-cycle pulse: tuning failed or refused |
| upd_flag | output | 1 | Tap update request, cleared by hardware |
| tap_field | output | 6 | Current or chosen sampling tap |
| upd_clear | input | 1 | Hardware has taken the tap; clears the flag |
| test_valid | output | 1 | Tuning-block test request |
| test_ready | input | 1 | Tester accepts the request |
| res_valid | input | 1 | Test verdict present |
| res_pass | input | 1 | Verdict: 1 pass, 0 fail |
| res_ready | output | 1 | Block accepts the verdict |

## Verification
The case hardest to reach is one where the final tap's update fails while every sweep update succeeded. The same tap value is written twice, once in the sweep and once as the final choice. The bench's flag responder counts how many times it has seen each tap value and can refuse only the second write. Ties between equal runs, and runs broken by a refused sweep update rather than a failed test, are also set up directly. Random pass patterns and random `test_ready` stalls are applied on top of these.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT_UPD, S_REQ, S_RES, S_DECIDE, S_FIN_ISSUE, S_FIN_WAIT
  } seq_state_e;
  localparam logic [2:0] MODE_TUNABLE = 3'd4;
endpackage

// File: rtl/tap_apply.sv
module tap_apply #(
  parameter int TAP_W       = 6,
  parameter int UPD_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [TAP_W:0]   val,
  input  logic             hw_clear,
  output logic             flag,
  output logic [TAP_W-1:0] field,
  output logic             fin,
  output logic             ok
);
  localparam int TMO_W = $clog2(UPD_TIMEOUT + 1);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      field <= '0;
      fin   <= 1'b0;
      ok    <= 1'b0;
      cnt   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        if (val[TAP_W]) begin
          fin <= 1'b1;
          ok  <= 1'b0;
        end else begin
          field <= val[TAP_W-1:0];
          flag  <= 1'b1;
          cnt   <= '0;
        end
      end else if (flag) begin
        if (hw_clear) begin
          flag <= 1'b0;
          fin  <= 1'b1;
          ok   <= 1'b1;
        end else if (cnt == TMO_W'(UPD_TIMEOUT - 1)) begin
          flag <= 1'b0;
          fin  <= 1'b1;
          ok   <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/streak_track.sv
module streak_track #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rec,
  input  logic             pass,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] pick,
  output logic             any
);
  localparam int LEN_W = IDX_W + 1;
  logic [LEN_W-1:0] cur, best, cur_inc;
  logic [IDX_W-1:0] best_end;

  assign cur_inc = cur + 1'b1;
  assign pick    = best_end - IDX_W'(best >> 1);
  assign any     = (best != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      best     <= '0;
      best_end <= '0;
    end else if (clr) begin
      cur      <= '0;
      best     <= '0;
      best_end <= '0;
    end else if (rec) begin
      if (pass) begin
        cur <= cur_inc;
        if (cur_inc > best) begin
          best     <= cur_inc;
          best_end <= idx;
        end
      end else begin
        cur <= '0;
      end
    end
  end
endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner
  import tap_tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int TAP_COUNT   = 40,
  parameter int UPD_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       mode,
  output logic             done,
  output logic             err,
  output logic             upd_flag,
  output logic [TAP_W-1:0] tap_field,
  input  logic             upd_clear,
  output logic             test_valid,
  input  logic             test_ready,
  input  logic             res_valid,
  input  logic             res_pass,
  output logic             res_ready
);
  localparam int IDX_W = $clog2(TAP_COUNT);

  seq_state_e       state;
  logic [IDX_W-1:0] idx, pick;
  logic             any, apply_go, apply_fin, apply_ok;
  logic             trk_clr, trk_rec, trk_pass, last;
  logic [TAP_W:0]   apply_val;

  assign apply_go   = (state == S_ISSUE) || (state == S_FIN_ISSUE);
  assign apply_val  = (state == S_FIN_ISSUE) ? (TAP_W+1)'(pick) : (TAP_W+1)'(idx);
  assign trk_clr    = (state == S_IDLE) && start;
  assign trk_rec    = ((state == S_WAIT_UPD) && apply_fin && !apply_ok) ||
                      ((state == S_RES) && res_valid);
  assign trk_pass   = (state == S_RES) && res_pass;
  assign last       = (idx == IDX_W'(TAP_COUNT - 1));
  assign test_valid = (state == S_REQ);
  assign res_ready  = (state == S_RES);

  tap_apply #(.TAP_W(TAP_W), .UPD_TIMEOUT(UPD_TIMEOUT)) u_apply (
    .clk(clk), .rst_n(rst_n), .go(apply_go), .val(apply_val),
    .hw_clear(upd_clear), .flag(upd_flag), .field(tap_field),
    .fin(apply_fin), .ok(apply_ok)
  );

  streak_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .rec(trk_rec),
    .pass(trk_pass), .idx(idx), .pick(pick), .any(any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (mode == MODE_TUNABLE) begin
            idx   <= '0;
            state <= S_ISSUE;
          end else begin
            err <= 1'b1;
          end
        end
        S_ISSUE: state <= S_WAIT_UPD;
        S_WAIT_UPD: if (apply_fin) begin
          if (apply_ok)  state <= S_REQ;
          else if (last) state <= S_DECIDE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_REQ: if (test_ready) state <= S_RES;
        S_RES: if (res_valid) begin
          if (last) state <= S_DECIDE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_DECIDE: begin
          if (any) state <= S_FIN_ISSUE;
          else begin
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_FIN_ISSUE: state <= S_FIN_WAIT;
        S_FIN_WAIT: if (apply_fin) begin
          done  <= apply_ok;
          err   <= !apply_ok;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tap_window_tuner_chk.sv
module tap_window_tuner_chk #(
  parameter int TAP_W     = 6,
  parameter int TAP_COUNT = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic             upd_flag,
  input logic [TAP_W-1:0] tap_field,
  input logic             test_valid,
  input logic             test_ready
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (upd_flag && $past(upd_flag)) |-> $stable(tap_field)); // R2
  AST_NO_TEST_IN_UPD: assert property (@(posedge clk) disable iff (!rst_n) upd_flag |-> !test_valid); // R2
  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) upd_flag |-> (int'(tap_field) < TAP_COUNT)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (test_valid && !test_ready) |=> test_valid); // R9
endmodule

bind tap_window_tuner tap_window_tuner_chk #(.TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .upd_flag(upd_flag),
  .tap_field(tap_field), .test_valid(test_valid), .test_ready(test_ready)
);

// File: tb/test_tap_window_tuner.sv
module test_tap_window_tuner;
  localparam int NT = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] mode = 3'd4;
  logic done, err, upd_flag, test_valid, res_ready;
  logic [5:0] tap_field;
  logic upd_clear = 1'b0, test_ready = 1'b0, res_valid = 1'b0, res_pass = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit pass_v [0:63];
  bit blk1 [0:63];
  bit blk2 [0:63];
  int app_cnt [0:63];
  int n_tests = 0, last_tap = -1;
  bit ord_bad = 0;
  bit exp_ok;
  int exp_tap, exp_tests;

  always #10 clk = ~clk;

  tap_window_tuner i_tap_window_tuner (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .done(done), .err(err),
    .upd_flag(upd_flag), .tap_field(tap_field), .upd_clear(upd_clear),
    .test_valid(test_valid), .test_ready(test_ready), .res_valid(res_valid),
    .res_pass(res_pass), .res_ready(res_ready)
  );

  task automatic check(input bit cond, input string req, input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Flag responder: clears the flag two cycles after it rises unless refused
  initial begin
    bit seen = 0, refuse = 0;
    int wc = 0;
    forever begin
      @(negedge clk);
      upd_clear = 1'b0;
      if (upd_flag) begin
        if (!seen) begin
          seen = 1; wc = 0;
          refuse = (app_cnt[tap_field] == 0) ? blk1[tap_field] : blk2[tap_field];
          app_cnt[tap_field]++;
        end
        wc++;
        if (!refuse && wc >= 2) upd_clear = 1'b1;
      end else seen = 0;
    end
  end

  // Tester: random accept stalls, verdict from pass_v
  initial begin
    int st = 0;
    forever begin
      @(negedge clk);
      case (st)
        0: if (test_valid) begin
          test_ready = ($urandom % 2) == 1;
          if (test_ready) st = 1;
        end
        1: begin
          test_ready = 1'b0;
          n_tests++;
          if (int'(tap_field) <= last_tap) ord_bad = 1;
          last_tap = int'(tap_field);
          res_valid = 1'b1;
          res_pass = pass_v[tap_field];
          st = 2;
        end
        default: if (!res_ready) begin
          res_valid = 1'b0;
          st = 0;
        end
      endcase
    end
  end

  function automatic void compute();
    int cur = 0, best = 0, endt = 0;
    exp_tests = 0;
    for (int i = 0; i < NT; i++) begin
      if (blk1[i]) cur = 0;
      else begin
        exp_tests++;
        if (pass_v[i]) begin
          cur++;
          if (cur > best) begin best = cur; endt = i; end
        end else cur = 0;
      end
    end
    exp_tap = endt - best / 2;
    exp_ok  = (best > 0) && !(blk1[exp_tap] ? 1'b0 : blk2[exp_tap]);
    if (best > 0 && blk1[exp_tap]) exp_ok = 0;
  endfunction

  function automatic void clear_vec();
    for (int i = 0; i < 64; i++) begin
      pass_v[i] = 0; blk1[i] = 0; blk2[i] = 0; app_cnt[i] = 0;
    end
  endfunction

  task automatic run_tune(input string tag);
    int n = 0;
    bit got_end = 0;
    compute();
    for (int i = 0; i < 64; i++) app_cnt[i] = 0;
    n_tests = 0; last_tap = -1; ord_bad = 0;
    @(negedge clk); mode = 3'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!got_end && n < 20000) begin
      if (done || err) got_end = 1;
      else begin @(negedge clk); n++; end
    end
    check(got_end, {tag, " R3 watchdog"}, n, 0);
    check(done == exp_ok, {tag, " R6/R7/R10 done"}, done, exp_ok);
    check(err == !exp_ok, {tag, " R7/R10 err"}, err, !exp_ok);
    check(n_tests == exp_tests, {tag, " R3 R4 R9 test count"}, n_tests, exp_tests);
    check(!ord_bad, {tag, " R3 ascending taps"}, ord_bad, 0);
    if (exp_ok) check(tap_field == 6'(exp_tap), {tag, " R5 R6 chosen tap"}, tap_field, exp_tap);
    @(negedge clk);
    check(!done && !err, {tag, " R6 single-cycle pulse"}, done | err, 0);
    if (exp_ok) check(tap_field == 6'(exp_tap), {tag, " R6 tap kept"}, tap_field, exp_tap);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_vec();
    repeat (3) @(negedge clk);
    check(!done && !err && !upd_flag && !test_valid && !res_ready, "R1 reset outputs", 
          {done, err, upd_flag, test_valid, res_ready}, 0);
    check(tap_field == 6'd0, "R1 reset tap", tap_field, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: refused mode
    mode = 3'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b1, "R8 err after bad mode", err, 1);
    check(!upd_flag && !test_valid, "R8 no flag/test", {upd_flag, test_valid}, 0);
    @(negedge clk);
    check(err == 1'b0 && !upd_flag && !test_valid, "R8 err one cycle", {err, upd_flag, test_valid}, 0);

    // R7: nothing passes
    clear_vec(); run_tune("allfail");
    // All pass: end 39, len 40 -> 19
    clear_vec(); for (int i = 0; i < NT; i++) pass_v[i] = 1; run_tune("allpass");
    // Single pass at tap 0 -> 0
    clear_vec(); pass_v[0] = 1; run_tune("edge0");
    // R5 tie: 3..6 and 20..23 -> keep earlier, 6-2=4
    clear_vec(); for (int i = 3; i < 7; i++) pass_v[i] = 1; for (int i = 20; i < 24; i++) pass_v[i] = 1;
    run_tune("tie");
    // R4: refused sweep update breaks 10..29 at 15
    clear_vec(); for (int i = 10; i < 30; i++) pass_v[i] = 1; blk1[15] = 1; run_tune("updbreak");
    // R10: final write refused (sweep of tap 19 succeeds)
    clear_vec(); for (int i = 0; i < NT; i++) pass_v[i] = 1; blk2[19] = 1; run_tune("finfail");
    // Random patterns
    for (int r = 0; r < 8; r++) begin
      clear_vec();
      for (int i = 0; i < NT; i++) begin
        pass_v[i] = ($urandom % 4) != 0;
        blk1[i] = ($urandom % 16) == 0;
      end
      run_tune("random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule